// File: doc/BRIEF.md
# Masked Outer-Product Accumulate Engine

This block holds a square matrix of integer accumulators (8 x 8 of 32 bits by default) and applies one compute instruction to it per accepted beat. Each instruction carries two operand vectors, `x` and `y`, of 16-bit scalars. In matrix form every cell (i, j) folds in a term built from `x[j]` and `y[i]`. In vector form only one chosen row is touched, and its cell j folds in a term built from `x[j]` and `y[j]`. The term is a product, a sum or a difference. It can then be shifted right. The new accumulator value can be clamped to the accumulator's integer range.

Two masks gate every instruction: one over rows and one over columns. Each mask is generated from a 3-bit mode and a 4-bit count carried with the instruction. A cell changes only when both its row bit and its column bit are set. In vector form the chosen row must also be enabled. Every other cell keeps its value.

Instructions arrive on a valid/ready port. `in_ready` is low during reset. From the first clock after reset it stays high, so the engine never applies back-pressure. A beat is taken on any rising edge where `in_valid` and `in_ready` are both high. Back-to-back beats are legal, and they land in order. The accumulator contents can be read at any time, one row at a time, through a plain combinational read port.

Top module: `opa_engine`

## Requirements
- R1: While `rst_n` is low, every accumulator cell is zero and `in_ready` is low.
- R2: After reset `in_ready` is high. A beat taken at rising edge k is visible on `rd_data` after rising edge k+1. Consecutive beats apply in order.
- R3: When `in_pw`=0 (matrix form), enabled cell (i, j) accumulates the term of `x[j]` (first operand) and `y[i]` (second operand).
- R4: When `in_pw`=1 (vector form), only row `in_psel` may change, and its enabled cell j accumulates the term of `x[j]` and `y[j]`.
- R5: `in_kind` selects the term: 0 gives a*b, 1 gives a+b, 2 gives a-b, and 3 behaves as 0.
- R6: When `in_signed`=1, operands and accumulators are two's complement. When it is 0, they are zero-extended unsigned values.
- R7: The term is computed exactly in 34 bits. It is then shifted right by `in_shift` (0..31). The shift is arithmetic in signed mode. In unsigned mode it is logical over the 34-bit pattern. The result is read as a signed 34-bit value.
- R8: When `in_sat`=1, the sum is clamped to [-2^31, 2^31-1] in signed mode or to [0, 2^32-1] in unsigned mode. When `in_sat`=0, it wraps modulo 2^32.
- R9: Each mask mode enables index k as follows: 0 enables every k, 1 enables even k, 2 enables odd k, 3 enables k < n, 4 enables k >= 8-n, 5 enables only k = n, and 6 or 7 enable nothing.
- R10: Mode 3 with n=0 enables nothing. Mode 5 with n >= 8 enables nothing. Mode 4 with n >= 8 enables every index.
- R11: A disabled cell keeps its exact value, even while other cells are being updated.
- R12: Row and column masks combine by AND. In vector form the row mask bit of `in_psel` must also be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction beat present |
| in_ready | output | 1 | Engine takes beats |
| in_x | input | N*MW | x vector, element j at bits j*MW |
| in_y | input | N*MW | y vector, element i at bits i*MW |
| in_pw | input | 1 | 0 = matrix form, 1 = vector form |
| in_kind | input | 2 | Term select (R5) |
| in_signed | input | 1 | Signed arithmetic |
| in_shift | input | SHW | Right shift of the term |
| in_sat | input | 1 | Clamp the sum |
| in_row_mode | input | 3 | Row mask mode |
| in_row_n | input | MNW | Row mask count or index |
| in_col_mode | input | 3 | Column mask mode |
| in_col_n | input | MNW | Column mask count or index |
| in_psel | input | PSW | Target row in vector form |
| rd_row | input | PSW | Row to read |
| rd_data | output | N*AW | Row contents, cell j at bits j*AW |

## Verification
The bench targets the mask boundaries: a first-n mask with n=0, a single-index mask past the last index, and a last-n mask with n above the dimension. A mask decoder that is off by one would touch a cell that must stay unchanged, or would skip a cell that should update.

Repeated products of -32768 * -32768 drive signed clamping, and 65535 * 65535 drives unsigned wrap. A saturation stage with a wrong bound or a wrong width would leave wrapped garbage in the accumulators, or would clamp values that should wrap.

Unsigned differences shifted right catch an arithmetic shift used where a logical one is required. Vector-form beats check that rows other than the chosen one stay unchanged and that `y[j]`, not `y[i]`, is paired with `x[j]`.

// File: rtl/opa_pkg.sv
package opa_pkg;
  localparam logic [2:0] MSK_ALL   = 3'd0;
  localparam logic [2:0] MSK_EVEN  = 3'd1;
  localparam logic [2:0] MSK_ODD   = 3'd2;
  localparam logic [2:0] MSK_FIRST = 3'd3;
  localparam logic [2:0] MSK_LAST  = 3'd4;
  localparam logic [2:0] MSK_ONLY  = 3'd5;

  localparam logic [1:0] TRM_MUL = 2'd0;
  localparam logic [1:0] TRM_ADD = 2'd1;
  localparam logic [1:0] TRM_SUB = 2'd2;

  typedef struct packed {
    logic sgn;
    logic sat;
  } opa_ctl_t;
endpackage

// File: rtl/opa_mask_gen.sv
module opa_mask_gen #(
  parameter int DIM = 8,
  parameter int MNW = 4
) (
  input  logic [2:0]     mode,
  input  logic [MNW-1:0] n,
  output logic [DIM-1:0] mask
);
  import opa_pkg::*;

  always_comb begin
    for (int k = 0; k < DIM; k++) begin
      case (mode)
        MSK_ALL:   mask[k] = 1'b1;
        MSK_EVEN:  mask[k] = (k % 2) == 0;
        MSK_ODD:   mask[k] = (k % 2) == 1;
        MSK_FIRST: mask[k] = k < int'(n);
        MSK_LAST:  mask[k] = (k + int'(n)) >= DIM;
        MSK_ONLY:  mask[k] = k == int'(n);
        default:   mask[k] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/opa_term.sv
module opa_term #(
  parameter int MW  = 16,
  parameter int SHW = 5,
  parameter int TW  = 2*MW+2
) (
  input  logic [MW-1:0]        a,
  input  logic [MW-1:0]        b,
  input  logic [1:0]           kind,
  input  logic                 sgn,
  input  logic [SHW-1:0]       sh,
  output logic signed [TW-1:0] term
);
  import opa_pkg::*;
  localparam int EXT = TW - MW;

  logic signed [TW-1:0] aw, bw, raw;
  logic [TW-1:0]        raw_u;

  always_comb begin
    aw = sgn ? {{EXT{a[MW-1]}}, a} : {{EXT{1'b0}}, a};
    bw = sgn ? {{EXT{b[MW-1]}}, b} : {{EXT{1'b0}}, b};
    case (kind)
      TRM_ADD: raw = aw + bw;
      TRM_SUB: raw = aw - bw;
      default: raw = aw * bw;
    endcase
    raw_u = raw;
    if (sgn) term = raw >>> sh;
    else     term = $signed(raw_u >> sh);
  end
endmodule

// File: rtl/opa_acc.sv
module opa_acc #(
  parameter int AW = 32,
  parameter int TW = 34
) (
  input  logic [AW-1:0]        z,
  input  logic signed [TW-1:0] term,
  input  logic                 sgn,
  input  logic                 sat,
  output logic [AW-1:0]        z_nxt
);
  localparam int SW = ((AW > TW) ? AW : TW) + 2;
  localparam logic signed [SW-1:0] SMAX = {{(SW-AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {{(SW-AW+1){1'b1}}, {(AW-1){1'b0}}};
  localparam logic signed [SW-1:0] UMAX = {{(SW-AW){1'b0}}, {AW{1'b1}}};

  logic signed [SW-1:0] zx, tx, s;

  always_comb begin
    zx = sgn ? {{(SW-AW){z[AW-1]}}, z} : {{(SW-AW){1'b0}}, z};
    tx = {{(SW-TW){term[TW-1]}}, term};
    s  = zx + tx;
    z_nxt = s[AW-1:0];
    if (sat) begin
      if (sgn) begin
        if (s > SMAX)      z_nxt = SMAX[AW-1:0];
        else if (s < SMIN) z_nxt = SMIN[AW-1:0];
      end else begin
        if (s < 0)         z_nxt = '0;
        else if (s > UMAX) z_nxt = UMAX[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/opa_engine.sv
module opa_engine #(
  parameter int N   = 8,
  parameter int MW  = 16,
  parameter int AW  = 32,
  parameter int SHW = 5,
  parameter int MNW = 4,
  parameter int PSW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N*MW-1:0]   in_x,
  input  logic [N*MW-1:0]   in_y,
  input  logic              in_pw,
  input  logic [1:0]        in_kind,
  input  logic              in_signed,
  input  logic [SHW-1:0]    in_shift,
  input  logic              in_sat,
  input  logic [2:0]        in_row_mode,
  input  logic [MNW-1:0]    in_row_n,
  input  logic [2:0]        in_col_mode,
  input  logic [MNW-1:0]    in_col_n,
  input  logic [PSW-1:0]    in_psel,
  input  logic [PSW-1:0]    rd_row,
  output logic [N*AW-1:0]   rd_data
);
  import opa_pkg::*;
  localparam int TW    = 2*MW + 2;
  localparam int CELLS = N * N;

  logic                 accept;
  logic [N-1:0]         row_mask, col_mask;
  logic [CELLS-1:0]     en_c, s1_en;
  logic signed [TW-1:0] term_c [CELLS];
  logic signed [TW-1:0] s1_term [CELLS];
  logic                 s1_valid;
  opa_ctl_t             s1_ctl;
  logic [AW-1:0]        z [CELLS];
  logic [AW-1:0]        z_nxt [CELLS];
  logic [CELLS*AW-1:0]  z_flat;

  // beat acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end
  assign accept = in_valid & in_ready;

  opa_mask_gen #(.DIM(N), .MNW(MNW)) u_rowm (
    .mode(in_row_mode), .n(in_row_n), .mask(row_mask));
  opa_mask_gen #(.DIM(N), .MNW(MNW)) u_colm (
    .mode(in_col_mode), .n(in_col_n), .mask(col_mask));

  // stage 1: per-cell term and enable
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic [MW-1:0] opb;
      assign opb = in_pw ? in_y[j*MW +: MW] : in_y[i*MW +: MW];
      assign en_c[i*N+j] = row_mask[i] & col_mask[j] &
                           (~in_pw | (in_psel == PSW'(i)));
      opa_term #(.MW(MW), .SHW(SHW), .TW(TW)) u_term (
        .a(in_x[j*MW +: MW]), .b(opb), .kind(in_kind),
        .sgn(in_signed), .sh(in_shift), .term(term_c[i*N+j]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_en    <= '0;
      s1_ctl   <= '0;
    end else begin
      s1_valid <= accept;
      s1_en    <= accept ? en_c : '0;
      if (accept) s1_ctl <= '{sgn: in_signed, sat: in_sat};
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int c = 0; c < CELLS; c++) s1_term[c] <= term_c[c];
    end
  end

  // stage 2: accumulate into enabled cells
  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    opa_acc #(.AW(AW), .TW(TW)) u_acc (
      .z(z[c]), .term(s1_term[c]), .sgn(s1_ctl.sgn),
      .sat(s1_ctl.sat), .z_nxt(z_nxt[c]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      z[c] <= '0;
      else if (s1_valid && s1_en[c])   z[c] <= z_nxt[c];
    end

    assign z_flat[c*AW +: AW] = z[c];
  end

  // row read port
  always_comb begin
    rd_data = '0;
    for (int j = 0; j < N; j++) begin
      if (int'(rd_row) < N) rd_data[j*AW +: AW] = z[int'(rd_row)*N + j];
    end
  end
endmodule

// File: rtl/opa_engine_chk.sv
module opa_engine_chk #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int MNW = 4,
  parameter int PSW = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_pw,
  input logic [PSW-1:0]    in_psel,
  input logic [2:0]        in_row_mode,
  input logic [2:0]        in_col_mode,
  input logic [MNW-1:0]    in_col_n,
  input logic [N-1:0]      row_mask,
  input logic              s1_valid,
  input logic [N*N-1:0]    s1_en,
  input logic [N*N*AW-1:0] z_flat
);
  logic [PSW-1:0] psel_q;
  logic [N*N-1:0] other_rows;

  always_ff @(posedge clk) psel_q <= in_psel;

  always_comb begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        other_rows[i*N+j] = (PSW'(i) != psel_q);
  end

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  assert_first_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_col_mode == 3'd3 && in_col_n == '0)
      |=> (s1_en == '0));

  assert_only_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_row_mode == 3'd5) |-> $onehot0(row_mask));

  assert_vector_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pw) |=> ((s1_en & other_rows) == '0));

  for (genvar c = 0; c < N*N; c++) begin : g_keep
    assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(s1_valid && s1_en[c]) |=> $stable(z_flat[c*AW +: AW]));
  end
endmodule

bind opa_engine opa_engine_chk #(.N(N), .AW(AW), .MNW(MNW), .PSW(PSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pw(in_pw), .in_psel(in_psel), .in_row_mode(in_row_mode),
  .in_col_mode(in_col_mode), .in_col_n(in_col_n), .row_mask(row_mask),
  .s1_valid(s1_valid), .s1_en(s1_en), .z_flat(z_flat));

// File: tb/tb_opa_engine.sv
module tb_opa_engine;
  localparam int N  = 8;
  localparam int MW = 16;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*MW-1:0] in_x = '0, in_y = '0;
  logic in_pw = 1'b0, in_signed = 1'b0, in_sat = 1'b0;
  logic [1:0] in_kind = '0;
  logic [4:0] in_shift = '0;
  logic [2:0] in_row_mode = '0, in_col_mode = '0;
  logic [3:0] in_row_n = '0, in_col_n = '0;
  logic [2:0] in_psel = '0, rd_row = '0;
  logic [N*AW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [MW-1:0] xv [N];
  logic [MW-1:0] yv [N];
  logic [AW-1:0] zm [N][N];

  always #4 clk = ~clk;

  opa_engine dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_pw(in_pw), .in_kind(in_kind),
    .in_signed(in_signed), .in_shift(in_shift), .in_sat(in_sat),
    .in_row_mode(in_row_mode), .in_row_n(in_row_n),
    .in_col_mode(in_col_mode), .in_col_n(in_col_n),
    .in_psel(in_psel), .rd_row(rd_row), .rd_data(rd_data));

  function automatic logic [N-1:0] mask_f(int mode, int n);
    logic [N-1:0] m;
    for (int k = 0; k < N; k++) begin
      case (mode)
        0: m[k] = 1'b1;
        1: m[k] = (k % 2) == 0;
        2: m[k] = (k % 2) == 1;
        3: m[k] = k < n;
        4: m[k] = k >= N - n;
        5: m[k] = k == n;
        default: m[k] = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic longint term_f(logic [MW-1:0] a, logic [MW-1:0] b,
                                    int kind, bit sgn, int sh);
    longint av, bv, raw, u;
    av = sgn ? longint'($signed(a)) : longint'(a);
    bv = sgn ? longint'($signed(b)) : longint'(b);
    raw = (kind == 1) ? av + bv : (kind == 2) ? av - bv : av * bv;
    if (sgn) return raw >>> sh;
    u = (raw & ((64'sd1 <<< 34) - 1)) >> sh;
    if (u >= (64'sd1 <<< 33)) u = u - (64'sd1 <<< 34);
    return u;
  endfunction

  function automatic logic [AW-1:0] acc_f(logic [AW-1:0] z, longint t,
                                          bit sgn, bit sat);
    longint s;
    s = (sgn ? longint'($signed(z)) : longint'(z)) + t;
    if (sat) begin
      if (sgn) begin
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
      end else begin
        if (s < 0) s = 0;
        if (s > 64'sd4294967295) s = 64'sd4294967295;
      end
    end
    return s[AW-1:0];
  endfunction

  task automatic send(bit pw, int kind, bit sgn, int sh, bit sat,
                      int rmode, int rn, int cmode, int cn, int psel);
    logic [N-1:0] rm, cm;
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      in_x[k*MW +: MW] = xv[k];
      in_y[k*MW +: MW] = yv[k];
    end
    in_pw = pw; in_kind = 2'(kind); in_signed = sgn; in_shift = 5'(sh);
    in_sat = sat; in_row_mode = 3'(rmode); in_row_n = 4'(rn);
    in_col_mode = 3'(cmode); in_col_n = 4'(cn); in_psel = 3'(psel);
    in_valid = 1'b1;
    rm = mask_f(rmode, rn);
    cm = mask_f(cmode, cn);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (rm[i] && cm[j] && (!pw || i == psel))
          zm[i][j] = acc_f(zm[i][j],
                           term_f(xv[j], pw ? yv[j] : yv[i], kind, sgn, sh),
                           sgn, sat);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(string tag);
    for (int r = 0; r < N; r++) begin
      rd_row = 3'(r);
      #1;
      for (int j = 0; j < N; j++) begin
        checks++;
        if (rd_data[j*AW +: AW] !== zm[r][j]) begin
          errors++;
          $display("FAIL %s cell(%0d,%0d) actual=%h expected=%h",
                   tag, r, j, rd_data[j*AW +: AW], zm[r][j]);
        end
      end
    end
  endtask

  task automatic set_vec(int xb, int xs, int yb, int ys);
    for (int k = 0; k < N; k++) begin
      xv[k] = 16'(xb + xs * k);
      yv[k] = 16'(yb + ys * k);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) zm[i][j] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 in_ready actual=%b expected=0", in_ready);
    end
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R2 in_ready actual=%b expected=1", in_ready);
    end

    // R3 matrix form, signed product
    set_vec(3, 5, -7, 2);
    send(0, 0, 1, 0, 0, 0, 0, 0, 0, 0); idle(); chk_all("R3 outer mul");
    // R4 vector form on row 5
    set_vec(100, -9, 11, 13);
    send(1, 0, 1, 0, 0, 0, 0, 0, 0, 5); idle(); chk_all("R4 pointwise");
    // R5 add, sub and kind 3
    set_vec(-300, 41, 77, -5);
    send(0, 1, 1, 0, 0, 0, 0, 0, 0, 0); idle(); chk_all("R5 add");
    send(0, 2, 1, 0, 0, 0, 0, 0, 0, 0); idle(); chk_all("R5 sub");
    send(0, 3, 1, 0, 0, 0, 0, 0, 0, 0); idle(); chk_all("R5 kind3");
    // R6 unsigned large operands
    set_vec(16'hF000, 97, 16'hE123, 311);
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); idle(); chk_all("R6 unsigned");
    // R7 shifts
    set_vec(-1234, -17, 555, 3);
    send(0, 0, 1, 3, 0, 0, 0, 0, 0, 0); idle(); chk_all("R7 arith shift");
    set_vec(5, 1, 9000, 7);
    send(0, 2, 0, 4, 0, 0, 0, 0, 0, 0); idle(); chk_all("R7 logic shift");
    // R8 signed clamp, then unsigned wrap
    set_vec(-32768, 0, -32768, 0);
    repeat (4) send(0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    idle(); chk_all("R8 signed sat");
    set_vec(32767, 0, -32768, 0);
    repeat (6) send(0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    idle(); chk_all("R8 signed sat low");
    set_vec(16'hFFFF, 0, 16'hFFFF, 0);
    repeat (3) send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(); chk_all("R8 unsigned wrap");
    // R9 each mask mode on both axes
    set_vec(21, 4, 19, -3);
    for (int m = 0; m < 8; m++) begin
      send(0, 1, 1, 0, 0, m, 3, (m + 2) % 8, 5, 0); idle();
      chk_all("R9 mask modes");
    end
    // R10 boundaries
    send(0, 0, 1, 0, 0, 0, 0, 3, 0, 0); idle(); chk_all("R10 first0");
    send(0, 0, 1, 0, 0, 5, 9, 0, 0, 0); idle(); chk_all("R10 only9");
    send(0, 0, 1, 0, 0, 4, 12, 4, 8, 0); idle(); chk_all("R10 last12");
    // R11 single cell update, neighbours unchanged
    send(0, 0, 1, 0, 0, 5, 2, 5, 3, 0); idle(); chk_all("R11 keep");
    // R12 vector form with row mask excluding chosen row
    send(1, 0, 1, 0, 0, 1, 0, 0, 0, 3); idle(); chk_all("R12 pw masked");
    send(1, 0, 1, 0, 0, 2, 0, 3, 6, 3); idle(); chk_all("R12 pw and");

    // R2 back-to-back random beats
    for (int t = 0; t < 300; t++) begin
      for (int k = 0; k < N; k++) begin
        xv[k] = 16'($urandom);
        yv[k] = 16'($urandom);
      end
      send(bit'($urandom % 4 == 0), int'($urandom % 4), bit'($urandom % 2),
           ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 3),
           bit'($urandom % 2), int'($urandom % 8), int'($urandom % 16),
           int'($urandom % 8), int'($urandom % 16), int'($urandom % 8));
      if (t % 50 == 49) begin
        idle();
        chk_all("R2 random stream");
      end
    end
    idle();
    chk_all("R2 random final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule